// File: doc/BRIEF.md
# Key-Unlocked Flash Row Controller

This block sits between a CPU-side register bus and an on-chip program flash array. Software picks a target row, loads a row's worth of words into a bank of write latches, and then chooses either a row erase or a row program. An operation launches only when two fixed key values have been written to the key register just before the start bit is set. Any stray or wrong write between the keys and the start cancels the unlock, and a start attempt without a valid unlock is refused and flagged.

While an erase or program cycle runs, the block holds the CPU in a stall for a fixed number of clock cycles, set by a parameter. During that time the register and latch writes are shut out. At the end of the cycle, the row is committed to the behavioural flash array in one step and the start bit drops by itself. An erase sets every word of the row to all ones. A program can only clear bits, so each word becomes its old value ANDed with its latch word.

The flash array has a separate read port, so the CPU can fetch words from program memory.

Top module: `flashrow_ctrl`

## Requirements
- R1: After reset, the control (bus address 0), low address (1), high address (2) and key (3) registers all read 0, and `cpu_stall` is low.
- R2: A control write with bit 0 (start) and bit 1 (write enable) set launches an operation only if the two bus writes just before it wrote 0x0055 and then 0x00AA to the key register.
- R3: A start is refused when the unlock is broken. The unlock breaks if any other register is written between the keys and the start, if a key value is wrong, or if the keys come in reverse order. A refused start leaves `cpu_stall` low and sets the error flag (control bit 3). The next accepted start clears the error flag.
- R4: A start write with bit 1 (write enable) clear is refused, even after a valid unlock, and sets the error flag.
- R5: `cpu_stall` rises in the cycle after the accepted start write and stays high for exactly OP_CYCLES cycles. Control bit 0 reads 1 during that time and reads 0 from the cycle in which `cpu_stall` falls.
- R6: With control bit 2 at 0 (erase), every one of the ROW_WORDS words of the selected row becomes all ones.
- R7: With control bit 2 at 1 (program), each word w of the selected row becomes its previous value ANDed with latch word w. Latch word w is loaded by `ltch_wr` with `ltch_idx` = w.
- R8: The row index is taken from low address register bits [ROW_LSB+ROW_IDX_W-1:ROW_LSB], which are bits [7:5] at the defaults. All other address bits, including the whole high address register, do not steer the row. Rows other than the selected one are left unchanged. The high register keeps its low 8 bits and reads them back.
- R9: While `cpu_stall` is high, bus writes to every register and latch writes have no effect. This includes key writes, so keys written during an operation do not unlock.
- R10: Each accepted start consumes the unlock, so a second start without fresh keys is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select for write and read |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data of the register selected by bus_addr |
| ltch_wr | input | 1 | Write-latch load strobe |
| ltch_idx | input | 5 | Write-latch word index |
| ltch_wdata | input | 24 | Write-latch word data |
| rd_addr | input | 8 | Flash array read word address |
| rd_data | output | 24 | Flash array read data |
| cpu_stall | output | 1 | Holds the CPU while an erase or program cycle runs |

## Verification
First, every row is erased, which sets the whole array to a known all-ones state. Next, one row is programmed twice using two unrelated latch patterns. Because the second result keeps only the bits both patterns share, a plain overwrite can be told apart from the AND rule. A programming target given with an in-row offset and noisy upper address bits shows whether the row slice is taken from the right bits and whether the neighbouring rows stay intact. The unlock is broken at each step in turn: a foreign write, a wrong second key, reversed keys, a clear write-enable, a reused unlock, and keys written during an operation. Each case separates a properly gated start from one that merely looks at the last key written.

// File: rtl/flashrow_pkg.sv
`timescale 1ns/1ps
package flashrow_pkg;
  localparam int BUS_W = 16;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ADRL = 2'd1,
    REG_ADRH = 2'd2,
    REG_KEY  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_HALF = 2'd1,
    UL_OPEN = 2'd2
  } unlock_e;

  localparam logic [BUS_W-1:0] KEY_FIRST  = 16'h0055;
  localparam logic [BUS_W-1:0] KEY_SECOND = 16'h00AA;

  localparam int CTRL_GO   = 0;
  localparam int CTRL_WEN  = 1;
  localparam int CTRL_PROG = 2;
endpackage

// File: rtl/flashrow_unlock.sv
`timescale 1ns/1ps
module flashrow_unlock
  import flashrow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic             other_wr,
  input  logic [BUS_W-1:0] key_val,
  output logic             armed
);
  unlock_e state_q, state_d;

  // Next-state: key writes advance or collapse the sequence, any other write collapses it.
  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      if (key_val == KEY_FIRST)
        state_d = UL_HALF;
      else if (key_val == KEY_SECOND && state_q == UL_HALF)
        state_d = UL_OPEN;
      else
        state_d = UL_IDLE;
    end else if (other_wr) begin
      state_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UL_IDLE;
    else if (key_wr || other_wr) state_q <= state_d;
  end

  assign armed = (state_q == UL_OPEN);
endmodule

// File: rtl/flashrow_timer.sv
`timescale 1ns/1ps
module flashrow_timer #(
  parameter int OP_CYCLES = 40,
  localparam int CNT_W = $clog2(OP_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign done = busy_q && (cnt_q == CNT_W'(OP_CYCLES - 1));
  assign busy = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start || busy_q) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/flashrow_latches.sv
`timescale 1ns/1ps
module flashrow_latches #(
  parameter int WORD_W    = 24,
  parameter int ROW_WORDS = 32,
  parameter int IDX_W     = $clog2(ROW_WORDS)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [IDX_W-1:0]                     idx,
  input  logic [WORD_W-1:0]                    wdata,
  output logic [ROW_WORDS-1:0][WORD_W-1:0]     row_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_data <= '1;
    end else if (wr_en) begin
      for (int w = 0; w < ROW_WORDS; w++) begin
        if (idx == IDX_W'(w)) row_data[w] <= wdata;
      end
    end
  end
endmodule

// File: rtl/flashrow_array.sv
`timescale 1ns/1ps
module flashrow_array #(
  parameter int WORD_W    = 24,
  parameter int ROW_WORDS = 32,
  parameter int NUM_ROWS  = 8,
  parameter int ROW_IDX_W = $clog2(NUM_ROWS),
  parameter int RD_ADDR_W = $clog2(NUM_ROWS * ROW_WORDS)
) (
  input  logic                             clk,
  input  logic                             commit,
  input  logic                             prog,
  input  logic [ROW_IDX_W-1:0]             row_sel,
  input  logic [ROW_WORDS-1:0][WORD_W-1:0] row_data,
  input  logic [RD_ADDR_W-1:0]             rd_addr,
  output logic [WORD_W-1:0]                rd_data
);
  localparam int DEPTH = NUM_ROWS * ROW_WORDS;

  logic [WORD_W-1:0] mem [DEPTH];

  // Whole-row commit in one edge; program can only clear bits.
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int w = 0; w < ROW_WORDS; w++) begin
        if (prog)
          mem[RD_ADDR_W'(int'(row_sel) * ROW_WORDS + w)] <=
            mem[RD_ADDR_W'(int'(row_sel) * ROW_WORDS + w)] & row_data[w];
        else
          mem[RD_ADDR_W'(int'(row_sel) * ROW_WORDS + w)] <= '1;
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flashrow_ctrl.sv
`timescale 1ns/1ps
module flashrow_ctrl
  import flashrow_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int ROW_WORDS = 32,
  parameter int NUM_ROWS  = 8,
  parameter int OP_CYCLES = 40,
  parameter int HI_W      = 8,
  localparam int LIDX_W    = $clog2(ROW_WORDS),
  localparam int RD_ADDR_W = $clog2(NUM_ROWS * ROW_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic                 ltch_wr,
  input  logic [LIDX_W-1:0]    ltch_idx,
  input  logic [WORD_W-1:0]    ltch_wdata,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 cpu_stall
);
  localparam int ROW_LSB   = $clog2(ROW_WORDS);
  localparam int ROW_IDX_W = $clog2(NUM_ROWS);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // Bus decode
  reg_sel_e sel;
  logic     busy, done, armed;
  logic     wr_ok, key_wr, other_wr, go_req, start;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_ok    = bus_wr && !busy;
  assign key_wr   = wr_ok && (sel == REG_KEY);
  assign other_wr = wr_ok && (sel != REG_KEY);
  assign go_req   = wr_ok && (sel == REG_CTRL) && bus_wdata[CTRL_GO];
  assign start    = go_req && armed && bus_wdata[CTRL_WEN];

  // Register state
  logic             wen_q, wen_d;
  logic             prog_q, prog_d;
  logic             err_q, err_d;
  logic [BUS_W-1:0] adr_lo_q, adr_lo_d;
  logic [HI_W-1:0]  adr_hi_q, adr_hi_d;

  always_comb begin
    wen_d    = wen_q;
    prog_d   = prog_q;
    err_d    = err_q;
    adr_lo_d = adr_lo_q;
    adr_hi_d = adr_hi_q;
    unique case (sel)
      REG_CTRL: begin
        wen_d  = bus_wdata[CTRL_WEN];
        prog_d = bus_wdata[CTRL_PROG];
        if (start)       err_d = 1'b0;
        else if (go_req) err_d = 1'b1;
      end
      REG_ADRL: adr_lo_d = bus_wdata;
      REG_ADRH: adr_hi_d = bus_wdata[HI_W-1:0];
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wen_q    <= 1'b0;
      prog_q   <= 1'b0;
      err_q    <= 1'b0;
      adr_lo_q <= '0;
      adr_hi_q <= '0;
    end else if (wr_ok) begin
      wen_q    <= wen_d;
      prog_q   <= prog_d;
      err_q    <= err_d;
      adr_lo_q <= adr_lo_d;
      adr_hi_q <= adr_hi_d;
    end
  end

  always_comb begin
    unique case (sel)
      REG_CTRL: bus_rdata = {{(BUS_W-4){1'b0}}, err_q, prog_q, wen_q, busy};
      REG_ADRL: bus_rdata = adr_lo_q;
      REG_ADRH: bus_rdata = BUS_W'(adr_hi_q);
      default:  bus_rdata = '0;
    endcase
  end

  // Sub-blocks
  flashrow_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .key_wr   (key_wr),
    .other_wr (other_wr),
    .key_val  (bus_wdata),
    .armed    (armed)
  );

  flashrow_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_core_n),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  logic [ROW_WORDS-1:0][WORD_W-1:0] latch_row;

  flashrow_latches #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS)) u_latches (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (ltch_wr && !busy),
    .idx      (ltch_idx),
    .wdata    (ltch_wdata),
    .row_data (latch_row)
  );

  flashrow_array #(
    .WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .NUM_ROWS(NUM_ROWS)
  ) u_array (
    .clk      (clk),
    .commit   (done),
    .prog     (prog_q),
    .row_sel  (adr_lo_q[ROW_LSB +: ROW_IDX_W]),
    .row_data (latch_row),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  assign cpu_stall = busy;
endmodule

// File: rtl/flashrow_checker.sv
`timescale 1ns/1ps
module flashrow_checker
  import flashrow_pkg::*;
#(
  parameter int OP_CYCLES = 40,
  parameter int HI_W      = 8
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic             cpu_stall,
  input logic             armed,
  input logic             err,
  input logic [BUS_W-1:0] adr_lo,
  input logic [HI_W-1:0]  adr_hi
);
  logic [31:0] stall_run;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)    stall_run <= '0;
    else if (cpu_stall) stall_run <= stall_run + 32'd1;
    else                stall_run <= '0;
  end

  p_start_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(cpu_stall) |-> $past(armed));

  p_arm_after_second_key_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(armed) |-> $past(bus_wr && bus_addr == REG_KEY && bus_wdata == KEY_SECOND));

  p_reject_sets_err_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && bus_addr == REG_CTRL && bus_wdata[CTRL_GO] && !cpu_stall && !armed) |=> err);

  p_start_needs_wen_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(cpu_stall) |-> $past(bus_wdata[CTRL_WEN]));

  p_stall_length_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(cpu_stall) |-> (stall_run == OP_CYCLES));

  p_stall_bound_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    cpu_stall |-> (stall_run < OP_CYCLES));

  p_busy_freeze_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cpu_stall && bus_wr) |=> ($stable(adr_lo) && $stable(adr_hi)));

  p_unlock_consumed_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(cpu_stall) |-> !armed);
endmodule

bind flashrow_ctrl flashrow_checker #(.OP_CYCLES(OP_CYCLES), .HI_W(HI_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .cpu_stall  (cpu_stall),
  .armed      (armed),
  .err        (err_q),
  .adr_lo     (adr_lo_q),
  .adr_hi     (adr_hi_q)
);

// File: tb/sim_flashrow_ctrl.sv
`timescale 1ns/1ps
module sim_flashrow_ctrl;
  localparam int WW  = 24;
  localparam int RW  = 32;
  localparam int NR  = 8;
  localparam int OPC = 40;

  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ltch_wr;
  logic [4:0]  ltch_idx;
  logic [23:0] ltch_wdata;
  logic [7:0]  rd_addr;
  logic [23:0] rd_data;
  logic        cpu_stall;

  flashrow_ctrl #(.WORD_W(WW), .ROW_WORDS(RW), .NUM_ROWS(NR), .OP_CYCLES(OPC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ltch_wr(ltch_wr),
    .ltch_idx(ltch_idx), .ltch_wdata(ltch_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .cpu_stall(cpu_stall)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Scoreboard queues: kind 0 = bus_rdata, 1 = rd_data, 2 = cpu_stall, 3 = value measured by driver
  int          q_kind[$];
  logic [23:0] q_exp[$];
  logic [23:0] q_act[$];
  string       q_tag[$];

  logic [23:0] model   [NR*RW];
  logic [23:0] latch_m [RW];

  int          m_kind;
  logic [23:0] m_exp, m_act;
  string       m_tag;

  // Monitor
  always @(negedge clk) begin
    if (q_kind.size() > 0) begin
      m_kind = q_kind.pop_front();
      m_exp  = q_exp.pop_front();
      m_act  = q_act.pop_front();
      m_tag  = q_tag.pop_front();
      case (m_kind)
        0:       m_act = {8'h00, bus_rdata};
        1:       m_act = rd_data;
        2:       m_act = {23'h0, cpu_stall};
        default: ;
      endcase
      n_chk++;
      if (m_act !== m_exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", m_tag, m_act, m_exp);
      end
    end
  end

  task automatic push(input int kind, input logic [23:0] exp, input logic [23:0] act, input string tag);
    q_kind.push_back(kind);
    q_exp.push_back(exp);
    q_act.push_back(act);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic ld(input int idx, input logic [23:0] d, input bit takes);
    @(posedge clk); #1;
    ltch_wr = 1'b1; ltch_idx = 5'(idx); ltch_wdata = d;
    @(posedge clk); #1;
    ltch_wr = 1'b0;
    if (takes) latch_m[idx] = d;
  endtask

  task automatic chk_reg(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    push(0, {8'h00, exp}, 24'h0, tag);
  endtask

  task automatic chk_word(input int addr, input logic [23:0] exp, input string tag);
    @(posedge clk); #1;
    rd_addr = 8'(addr);
    push(1, exp, 24'h0, tag);
  endtask

  task automatic measure(output int n);
    n = 0;
    @(negedge clk);
    while (cpu_stall) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic apply_model(input int row, input bit prog);
    for (int w = 0; w < RW; w++)
      model[row*RW + w] = prog ? (model[row*RW + w] & latch_m[w]) : 24'hFFFFFF;
  endtask

  task automatic run_op(input logic [15:0] hi, input logic [15:0] lo, input bit prog, input string tag);
    int n;
    wr(2'd2, hi);
    wr(2'd1, lo);
    wr(2'd3, 16'h0055);
    wr(2'd3, 16'h00AA);
    wr(2'd0, {13'h0, prog, 2'b11});
    measure(n);
    push(3, 24'(OPC), 24'(n), tag);
    apply_model(int'(lo[7:5]), prog);
  endtask

  task automatic expect_no_op(input string tag);
    int n;
    measure(n);
    push(3, 24'h0, 24'(n), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 16'h0;
    ltch_wr = 1'b0; ltch_idx = 5'd0; ltch_wdata = 24'h0; rd_addr = 8'h0;
    for (int w = 0; w < RW; w++) latch_m[w] = 24'hFFFFFF;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    push(2, 24'h0, 24'h0, "R1 stall");
    chk_reg(2'd0, 16'h0000, "R1 ctrl");
    chk_reg(2'd1, 16'h0000, "R1 addr lo");
    chk_reg(2'd2, 16'h0000, "R1 addr hi");
    chk_reg(2'd3, 16'h0000, "R1 key");

    // R6 erase every row
    for (int r = 0; r < NR; r++) run_op(16'h0, 16'(r*RW), 1'b0, "R6 erase length");
    chk_word(0, 24'hFFFFFF, "R6 row0 w0");
    chk_word(NR*RW-1, 24'hFFFFFF, "R6 last word");
    chk_word(2*RW+13, 24'hFFFFFF, "R6 row2 w13");

    // R7 program row 3 through an in-row offset
    for (int w = 0; w < RW; w++) ld(w, 24'(w * 24'h050301) ^ 24'h3C5AA5, 1'b1);
    run_op(16'h0, 16'(3*RW + 9), 1'b1, "R7 program length");
    for (int w = 0; w < RW; w++) chk_word(3*RW + w, model[3*RW + w], "R7 first program");
    chk_word(2*RW + 31, 24'hFFFFFF, "R8 row below untouched");
    chk_word(4*RW, 24'hFFFFFF, "R8 row above untouched");

    // R7 second program clears only shared bits
    for (int w = 0; w < RW; w++) ld(w, ~24'(w * 24'h001111), 1'b1);
    run_op(16'h0, 16'(3*RW), 1'b1, "R7 reprogram length");
    for (int w = 0; w < RW; w += 5) chk_word(3*RW + w, model[3*RW + w], "R7 AND result");

    // R8 upper address bits and high register do not steer the row
    run_op(16'h0001, 16'h4CA7, 1'b1, "R8 program length");
    chk_reg(2'd2, 16'h0001, "R8 high readback");
    chk_word(5*RW, model[5*RW], "R8 row5 w0");
    chk_word(5*RW + 31, model[5*RW + 31], "R8 row5 w31");
    chk_word(4*RW + 31, 24'hFFFFFF, "R8 row4 untouched");
    chk_word(6*RW, 24'hFFFFFF, "R8 row6 untouched");

    // R5 stall window and start bit
    wr(2'd2, 16'h0);
    wr(2'd1, 16'h0);
    wr(2'd3, 16'h0055);
    wr(2'd3, 16'h00AA);
    wr(2'd0, 16'h0003);
    chk_reg(2'd0, 16'h0003, "R5 go bit during op");
    measure(n);
    push(3, 24'(OPC - 2), 24'(n), "R5 remaining stall cycles");
    chk_reg(2'd0, 16'h0002, "R5 go bit cleared");
    push(2, 24'h0, 24'h0, "R5 stall released");
    apply_model(0, 1'b0);

    // R3 foreign write between keys and start
    wr(2'd3, 16'h0055);
    wr(2'd3, 16'h00AA);
    wr(2'd1, 16'(3*RW));
    wr(2'd0, 16'h0003);
    expect_no_op("R3 foreign write");
    chk_reg(2'd0, 16'h000A, "R3 err after foreign write");
    chk_word(3*RW, model[3*RW], "R3 row kept");

    // R3 wrong second key
    wr(2'd3, 16'h0055);
    wr(2'd3, 16'h00AB);
    wr(2'd0, 16'h0003);
    expect_no_op("R3 wrong key");

    // R3 reversed keys
    wr(2'd3, 16'h00AA);
    wr(2'd3, 16'h0055);
    wr(2'd0, 16'h0003);
    expect_no_op("R3 reversed keys");
    chk_reg(2'd0, 16'h000A, "R3 err still set");

    // R3 accepted start clears err
    run_op(16'h0, 16'(6*RW), 1'b0, "R3 valid op length");
    chk_reg(2'd0, 16'h0002, "R3 err cleared");

    // R4 write enable clear
    wr(2'd3, 16'h0055);
    wr(2'd3, 16'h00AA);
    wr(2'd0, 16'h0001);
    expect_no_op("R4 no wen");
    chk_reg(2'd0, 16'h0008, "R4 err set");

    // R10 unlock consumed
    run_op(16'h0, 16'(6*RW), 1'b0, "R10 first op length");
    wr(2'd0, 16'h0003);
    expect_no_op("R10 reused unlock");
    chk_reg(2'd0, 16'h000A, "R10 err");

    // R9 writes during an operation are ignored
    wr(2'd1, 16'(1*RW));
    wr(2'd3, 16'h0055);
    wr(2'd3, 16'h00AA);
    wr(2'd0, 16'h0007);
    wr(2'd1, 16'h0BAD);
    wr(2'd2, 16'h00FF);
    wr(2'd3, 16'h0055);
    wr(2'd3, 16'h00AA);
    wr(2'd0, 16'h0000);
    ld(0, 24'h000000, 1'b0);
    measure(n);
    apply_model(1, 1'b1);
    chk_reg(2'd1, 16'(1*RW), "R9 addr lo kept");
    chk_reg(2'd2, 16'h0000, "R9 addr hi kept");
    chk_reg(2'd0, 16'h0006, "R9 ctrl kept");
    chk_word(1*RW + 7, model[1*RW + 7], "R9 row1 programmed");
    wr(2'd0, 16'h0007);
    expect_no_op("R9 keys during op ignored");
    run_op(16'h0, 16'(2*RW), 1'b1, "R9 later op length");
    chk_word(2*RW, model[2*RW], "R9 latch write ignored");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule